// File: doc/BRIEF.md
# Banked Main-Memory Controller with DMA Takeover

This block is the main memory of a small 16-bit CPU whose memory is addressed in words. The CPU presents one of two addresses, the program counter or the ALU result, together with write data and a write enable. A DMA port can take the memory over completely. When its request flag is high, the DMA port supplies the address, the write data and the write strobe, and the CPU's own signals have no effect.

Storage has two parts: a writable RAM and a fixed read-only image. Every write lands in RAM. A two-bit bank register chooses, separately for the lower and the upper half of the address space, whether a read returns RAM or the read-only image. A write to one reserved address loads that bank register. A second reserved address is a general-purpose I/O word: writing it drives the output lines, and reading it returns the input lines whatever the bank setting. Bit 10 of the read data is also brought out on its own pin, as the flag that tells the sequencer an instruction needs a second word.

Addresses are byte addresses, and bit 0 is ignored. Reads are combinational and writes take effect on the rising clock edge. The RAM depth is a parameter. With RAM_AW = 15 the RAM holds the full 32K words; the default is smaller, and the RAM then repeats across the space.

Top module: `mem_banked_ctrl`

## Requirements
- R1: When dma_req is 0, the access address is pc_addr if addr_sel is 0 and alu_addr if addr_sel is 1.
- R2: When dma_req is 1, the address, write data and write enable come only from dma_addr, dma_wdata and dma_we. In that state a high cpu_we writes nothing.
- R3: A write stores its data in RAM word addr[RAM_AW:1] at the rising clock edge, whatever the bank setting. A later read of that word with RAM selected returns the data.
- R4: While the effective write enable is high, rdata is 0x0000 and const_needed is 0.
- R5: For reads, bank bit 0 selects the lower half (addr[15]=0) and bank bit 1 selects the upper half (addr[15]=1). A bit value of 1 means the read-only image and 0 means RAM.
- R6: A write to byte address 0xFFAE loads data bits [1:0] into the bank register. Writes to any other address leave the bank register unchanged.
- R7: Reset (rst_n low) sets the bank register to 0b10, which puts RAM low and the image high, and sets gpo to 0x0000.
- R8: A write to byte address 0xFFFE sets gpo to the write data on the clock edge. A read of 0xFFFE returns gpi in every bank setting.
- R9: const_needed always equals bit 10 of rdata.
- R10: The read-only image holds, at word index i = addr[15:1], the value (i * 0x9E37 mod 2^16) XOR ROM_SEED. The default ROM_SEED is 0x5A5A.
- R11: A write to 0xFFAE also stores its data in the RAM word underneath that address, and a read with RAM selected there returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes happen on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the bank and output registers |
| addr_sel | input | 1 | CPU address source: 0 selects the program counter, 1 selects the ALU |
| pc_addr | input | 16 | Program-counter byte address |
| alu_addr | input | 16 | ALU-result byte address |
| cpu_wdata | input | 16 | CPU write data |
| cpu_we | input | 1 | CPU write enable |
| dma_req | input | 1 | DMA takeover request |
| dma_addr | input | 16 | DMA byte address |
| dma_wdata | input | 16 | DMA write data |
| dma_we | input | 1 | DMA write strobe |
| gpi | input | 16 | General-purpose input lines |
| gpo | output | 16 | General-purpose output lines |
| rdata | output | 16 | Combinational read data |
| const_needed | output | 1 | Bit 10 of rdata |

## Verification
Two functions can meet in one cycle. A write can hit a reserved address and at the same time update the RAM word beneath it. A DMA takeover can coincide with the CPU asserting its own write. The bench loads the bank register through 0xFFAE, switches to all-RAM, and reads that word back to confirm both the bank load and the RAM copy. It then raises dma_req while cpu_we is high with a CPU address already holding known data, and confirms that this word is unchanged and that only the DMA address received the DMA data.

// File: rtl/mem_ctrl_pkg.sv
`timescale 1ns/1ps
package mem_ctrl_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;
    localparam int WIDX_W = ADDR_W - 1;
    localparam int BANK_W = 2;

    localparam logic [ADDR_W-1:0] BANK_REG_ADDR = 16'hFFAE;
    localparam logic [ADDR_W-1:0] GPIO_ADDR     = 16'hFFFE;
    localparam logic [BANK_W-1:0] BANK_RESET    = 2'b10;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              we;
    } mem_req_t;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [DATA_W-1:0] gpo;
    } ctrl_state_t;

    function automatic logic [DATA_W-1:0] rom_image(input logic [WIDX_W-1:0] idx,
                                                    input logic [DATA_W-1:0] seed);
        logic [31:0] prod;
        prod = 32'(idx) * 32'h0000_9E37;
        return prod[DATA_W-1:0] ^ seed;
    endfunction

endpackage

// File: rtl/mem_src_sel.sv
`timescale 1ns/1ps
module mem_src_sel
    import mem_ctrl_pkg::*;
(
    input  logic              addr_sel,
    input  logic [ADDR_W-1:0] pc_addr,
    input  logic [ADDR_W-1:0] alu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_we,
    input  logic              dma_req,
    input  logic [ADDR_W-1:0] dma_addr,
    input  logic [DATA_W-1:0] dma_wdata,
    input  logic              dma_we,
    output mem_req_t          req
);

    mem_req_t cpu_req;

    always_comb begin
        cpu_req.addr  = addr_sel ? alu_addr : pc_addr;
        cpu_req.wdata = cpu_wdata;
        cpu_req.we    = cpu_we;
        if (dma_req) begin
            req.addr  = dma_addr;
            req.wdata = dma_wdata;
            req.we    = dma_we;
        end else begin
            req = cpu_req;
        end
    end

endmodule

// File: rtl/mem_ctrl_regs.sv
`timescale 1ns/1ps
module mem_ctrl_regs
    import mem_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  mem_req_t          req,
    output logic [BANK_W-1:0] bank,
    output logic [DATA_W-1:0] gpo
);

    ctrl_state_t state_d, state_q;
    logic        hit_bank, hit_gpio;

    always_comb begin
        hit_bank = req.we && (req.addr[ADDR_W-1:1] == BANK_REG_ADDR[ADDR_W-1:1]);
        hit_gpio = req.we && (req.addr[ADDR_W-1:1] == GPIO_ADDR[ADDR_W-1:1]);
        state_d  = state_q;
        if (hit_bank) state_d.bank = req.wdata[BANK_W-1:0];
        if (hit_gpio) state_d.gpo  = req.wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.bank <= BANK_RESET;
            state_q.gpo  <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign bank = state_q.bank;
    assign gpo  = state_q.gpo;

    // R6: a write to the bank address loads the low data bits
    p_bank_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req.we && req.addr[ADDR_W-1:1] == 15'h7FD7) |=> (bank == $past(req.wdata[1:0])));

    // R6: any other cycle keeps the bank setting
    p_bank_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(req.we && req.addr[ADDR_W-1:1] == 15'h7FD7) |=> $stable(bank));

    // R8: a write to the I/O word drives the output lines
    p_gpo_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req.we && req.addr[ADDR_W-1:1] == 15'h7FFF) |=> (gpo == $past(req.wdata)));

endmodule

// File: rtl/mem_ram.sv
`timescale 1ns/1ps
module mem_ram
    import mem_ctrl_pkg::*;
#(
    parameter int RAM_AW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [RAM_AW-1:0] idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << RAM_AW;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wdata;
    end

    assign rdata = mem[idx];

    // R3: the written word holds the data after the edge
    p_ram_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem[$past(idx)] == $past(wdata)));

endmodule

// File: rtl/mem_banked_ctrl.sv
`timescale 1ns/1ps
module mem_banked_ctrl
    import mem_ctrl_pkg::*;
#(
    parameter int          RAM_AW   = 10,
    parameter logic [15:0] ROM_SEED = 16'h5A5A
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        addr_sel,
    input  logic [15:0] pc_addr,
    input  logic [15:0] alu_addr,
    input  logic [15:0] cpu_wdata,
    input  logic        cpu_we,
    input  logic        dma_req,
    input  logic [15:0] dma_addr,
    input  logic [15:0] dma_wdata,
    input  logic        dma_we,
    input  logic [15:0] gpi,
    output logic [15:0] gpo,
    output logic [15:0] rdata,
    output logic        const_needed
);

    mem_req_t          req;
    logic [BANK_W-1:0] bank;
    logic [DATA_W-1:0] ram_rd, read_val;
    logic [WIDX_W-1:0] word_idx;
    logic              is_gpio, pick_rom;

    mem_src_sel u_src (
        .addr_sel  (addr_sel),
        .pc_addr   (pc_addr),
        .alu_addr  (alu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_we    (cpu_we),
        .dma_req   (dma_req),
        .dma_addr  (dma_addr),
        .dma_wdata (dma_wdata),
        .dma_we    (dma_we),
        .req       (req)
    );

    mem_ctrl_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .bank  (bank),
        .gpo   (gpo)
    );

    mem_ram #(.RAM_AW(RAM_AW)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (req.we),
        .idx   (req.addr[RAM_AW:1]),
        .wdata (req.wdata),
        .rdata (ram_rd)
    );

    always_comb begin
        word_idx = req.addr[ADDR_W-1:1];
        is_gpio  = (word_idx == GPIO_ADDR[ADDR_W-1:1]);
        pick_rom = req.addr[ADDR_W-1] ? bank[1] : bank[0];
        if (is_gpio)       read_val = gpi;
        else if (pick_rom) read_val = rom_image(word_idx, ROM_SEED);
        else               read_val = ram_rd;
        rdata        = req.we ? '0 : read_val;
        const_needed = rdata[10];
    end

    // R4: a write in progress blanks the read outputs
    p_write_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req ? dma_we : cpu_we) |-> (rdata == 16'h0000 && !const_needed));

    // R8: the I/O word returns the input lines on a CPU read from the program counter
    p_gpio_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_req && !cpu_we && !addr_sel && pc_addr[15:1] == 15'h7FFF) |-> (rdata == gpi));

endmodule

// File: tb/mem_banked_ctrl_test.sv
`timescale 1ns/1ps
module mem_banked_ctrl_test;

    localparam int RAM_AW = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_sel = 1'b0;
    logic [15:0] pc_addr = '0, alu_addr = '0, cpu_wdata = '0;
    logic        cpu_we = 1'b0;
    logic        dma_req = 1'b0;
    logic [15:0] dma_addr = '0, dma_wdata = '0;
    logic        dma_we = 1'b0;
    logic [15:0] gpi = '0;
    logic [15:0] gpo, rdata;
    logic        const_needed;

    always #5 clk = ~clk;

    mem_banked_ctrl #(.RAM_AW(RAM_AW)) uut (
        .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .pc_addr(pc_addr),
        .alu_addr(alu_addr), .cpu_wdata(cpu_wdata), .cpu_we(cpu_we),
        .dma_req(dma_req), .dma_addr(dma_addr), .dma_wdata(dma_wdata),
        .dma_we(dma_we), .gpi(gpi), .gpo(gpo), .rdata(rdata),
        .const_needed(const_needed)
    );

    typedef struct {
        logic [15:0] rd;
        logic        chk_gp;
        logic [15:0] gp;
        string       tag;
    } item_t;

    item_t       sb_q[$];
    event        sample_ev;
    int          n_vec = 0, n_bad = 0;
    bit          done = 0;

    logic [15:0] ram_m [int];
    logic [1:0]  bank_m;
    logic [15:0] gpo_m;

    function automatic logic [15:0] rom_f(input logic [15:0] a);
        int unsigned p;
        p = int'(a[15:1]) * 32'h9E37;
        return p[15:0] ^ 16'h5A5A;
    endfunction

    function automatic logic [15:0] model_read(input logic [15:0] a);
        logic rom_sel;
        if (a[15:1] == 15'h7FFF) return gpi;
        rom_sel = a[15] ? bank_m[1] : bank_m[0];
        if (rom_sel) return rom_f(a);
        return ram_m[int'(a[RAM_AW:1])];
    endfunction

    task automatic model_write(input logic [15:0] a, input logic [15:0] d);
        ram_m[int'(a[RAM_AW:1])] = d;
        if (a[15:1] == 15'h7FD7) bank_m = d[1:0];
        if (a[15:1] == 15'h7FFF) gpo_m = d;
    endtask

    task automatic push(input logic [15:0] rd, input logic chk, input logic [15:0] gp,
                        input string tag);
        item_t it;
        it.rd = rd; it.chk_gp = chk; it.gp = gp; it.tag = tag;
        sb_q.push_back(it);
        -> sample_ev;
        #1;
    endtask

    // CPU access; for reads the expectation comes from the model
    task automatic cpu_op(input logic sel, input logic [15:0] pa, input logic [15:0] aa,
                          input logic we, input logic [15:0] wd, input string tag);
        logic [15:0] a;
        @(negedge clk);
        dma_req = 0; dma_we = 0;
        addr_sel = sel; pc_addr = pa; alu_addr = aa; cpu_we = we; cpu_wdata = wd;
        a = sel ? aa : pa;
        #2;
        push(we ? 16'h0000 : model_read(a), 1'b0, 16'h0, tag);
        if (we) begin
            @(posedge clk);
            model_write(a, wd);
        end
    endtask

    task automatic dma_op(input logic [15:0] da, input logic dwe, input logic [15:0] dd,
                          input logic [15:0] cpu_a, input logic cwe, input string tag);
        @(negedge clk);
        dma_req = 1; dma_addr = da; dma_we = dwe; dma_wdata = dd;
        addr_sel = 0; pc_addr = cpu_a; cpu_we = cwe; cpu_wdata = 16'hDEAD;
        #2;
        push(dwe ? 16'h0000 : model_read(da), 1'b0, 16'h0, tag);
        if (dwe) begin
            @(posedge clk);
            model_write(da, dd);
        end
    endtask

    task automatic check_gpo(input string tag);
        @(negedge clk);
        dma_req = 0; cpu_we = 0; dma_we = 0; addr_sel = 0; pc_addr = 16'h0010;
        #2;
        push(model_read(16'h0010), 1'b1, gpo_m, tag);
    endtask

    initial begin : monitor
        item_t it;
        forever begin
            @(sample_ev);
            while (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                n_vec++;
                if (rdata !== it.rd || const_needed !== it.rd[10]) begin
                    n_bad++;
                    $display("FAIL %s: rdata=%h cn=%b expected rdata=%h cn=%b",
                             it.tag, rdata, const_needed, it.rd, it.rd[10]);
                end
                if (it.chk_gp) begin
                    n_vec++;
                    if (gpo !== it.gp) begin
                        n_bad++;
                        $display("FAIL %s: gpo=%h expected %h", it.tag, gpo, it.gp);
                    end
                end
            end
        end
    end

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin : watchdog
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin : stimulus
        bank_m = 2'b10; gpo_m = 16'h0000;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R7: reset values: gpo zero, upper half reads the image
        check_gpo("R7 gpo after reset");
        cpu_op(0, 16'h8002, 16'h0, 0, 16'h0, "R7 R10 upper half is image after reset");
        cpu_op(0, 16'hC0A4, 16'h0, 0, 16'h0, "R10 image word");

        // R3 R1 R4: write through the PC address, read through both sources
        cpu_op(0, 16'h0010, 16'h0000, 1, 16'h1234, "R4 R3 cpu write blanks rdata");
        cpu_op(1, 16'h0200, 16'h0010, 0, 16'h0, "R1 alu address selected");
        cpu_op(0, 16'h0011, 16'h0200, 0, 16'h0, "R1 pc address selected, bit0 ignored");
        cpu_op(0, 16'h0012, 16'h0, 1, 16'h0400, "R3 write with bit10 set");
        cpu_op(0, 16'h0012, 16'h0, 0, 16'h0, "R9 const_needed follows bit10");

        // R3: write into the upper half while it reads the image
        cpu_op(1, 16'h0, 16'h8020, 1, 16'hBEEF, "R3 write under image");
        cpu_op(1, 16'h0, 16'h8020, 0, 16'h0, "R3 upper read still image");

        // R6 R11: bank 00 via 0xFFAE, data low bits 00
        cpu_op(1, 16'h0, 16'hFFAE, 1, 16'hA55C, "R6 bank write 00");
        cpu_op(1, 16'h0, 16'h8020, 0, 16'h0, "R5 R3 bank 00 upper RAM");
        cpu_op(1, 16'h0, 16'h0010, 0, 16'h0, "R5 bank 00 lower RAM");
        cpu_op(1, 16'h0, 16'hFFAE, 0, 16'h0, "R11 RAM copy under bank address");

        // R6: a write elsewhere with low bits 11 leaves the bank alone
        cpu_op(0, 16'h0040, 16'h0, 1, 16'h0003, "R6 unrelated write");
        cpu_op(0, 16'h8020, 16'h0, 0, 16'h0, "R6 bank unchanged after unrelated write");

        // R5: bank 01
        cpu_op(0, 16'hFFAE, 16'h0, 1, 16'hFFF1, "R6 bank write 01");
        cpu_op(0, 16'h0010, 16'h0, 0, 16'h0, "R5 bank 01 lower image");
        cpu_op(0, 16'h8020, 16'h0, 0, 16'h0, "R5 bank 01 upper RAM");

        // R5: bank 11
        cpu_op(0, 16'hFFAE, 16'h0, 1, 16'h0003, "R6 bank write 11");
        cpu_op(0, 16'h0010, 16'h0, 0, 16'h0, "R5 bank 11 lower image");
        cpu_op(0, 16'h8020, 16'h0, 0, 16'h0, "R5 bank 11 upper image");

        // R8: I/O word
        cpu_op(0, 16'hFFFE, 16'h0, 1, 16'h3C5A, "R8 gpo write");
        check_gpo("R8 gpo value");
        gpi = 16'h0F0F;
        cpu_op(0, 16'hFFFE, 16'h0, 0, 16'h0, "R8 gpi read bank 11");
        cpu_op(0, 16'hFFAE, 16'h0, 1, 16'h0000, "R6 bank write 00");
        gpi = 16'hF4F0;
        cpu_op(1, 16'h0, 16'hFFFF, 0, 16'h0, "R8 gpi read bank 00");

        // R2: DMA takes over while the CPU asserts a write
        dma_op(16'h0010, 0, 16'h0, 16'h0012, 1, "R2 dma read, cpu write ignored");
        cpu_op(0, 16'h0012, 16'h0, 0, 16'h0, "R2 cpu target untouched");
        dma_op(16'h0030, 1, 16'h0777, 16'h0012, 1, "R4 R2 dma write blanks rdata");
        cpu_op(0, 16'h0030, 16'h0, 0, 16'h0, "R2 R9 dma data stored");
        cpu_op(0, 16'h0012, 16'h0, 0, 16'h0, "R2 cpu target still untouched");

        // R4: the CPU write enable is ignored for blanking under DMA
        dma_op(16'h0010, 0, 16'h0, 16'h0010, 1, "R4 R2 dma read with cpu_we high");

        @(negedge clk);
        finish_run();
    end

endmodule